// File: doc/BRIEF.md
# Register Rename Status Table

This block holds the architectural register file of an out-of-order core together with a per-register producer tag. Each register is either current, so its stored value is valid, or waiting, so it names the reservation-station tag that will deliver its next value. An issue port reads two source registers in one cycle. For each source it returns either a ready value or the tag of the pending producer. In the same cycle it records the issuing instruction's tag as the new producer of its destination register.

A single result bus carries one tag and one value per cycle. Every register waiting on that tag takes the value and becomes current. Any register that has since been renamed to another tag ignores it. Because writeback is gated on the tag match, an older result cannot overwrite a younger rename. Write-after-write and write-after-read ordering therefore needs no issue stall.

Each entry is a two-state machine. In `ENT_CURRENT` the register is ready and the tag is 0. In `ENT_WAITING` it holds a nonzero producer tag. The four transitions are:
- rename: current to waiting, on issue.
- re-rename: waiting to waiting with a new tag.
- capture: waiting to current, on a matching result.
- capture-and-rename: stays waiting with the new tag, and still stores the value.

Top module: `rnt_table`

## Requirements
- R1: A synchronous reset, active high on `rst`, makes every register current with value 0 and tag 0.
- R2: An issue with `iss_valid`=1, `iss_dst_en`=1 and a nonzero `iss_tag` makes register `iss_dst` waiting on `iss_tag` from the next cycle.
- R3: A result with `res_valid`=1 whose `res_tag` equals a waiting register's tag stores `res_value` there and makes that register current from the next cycle.
- R4: A result whose tag differs from a register's tag, or any result seen by a current register, leaves that register's value and tag unchanged. This includes a register renamed to a younger tag after the older result's producer was recorded.
- R5: Source lookup of a current register gives ready=1, the stored value and tag 0. Lookup of a waiting register with no matching result gives ready=0, value 0 and the waiting tag.
- R6: When a looked-up source is waiting on the tag carried by a valid result in the same cycle, the lookup returns ready=1 with `res_value` and tag 0.
- R7: When a register is renamed in the same cycle that it captures a matching result, the value is stored but the register stays waiting on the new tag.
- R8: An issue with `iss_tag` = 0, or with `iss_dst_en` = 0, renames nothing.
- R9: Source lookups in a cycle see the table as it was before that cycle's rename, so an instruction naming its own destination as a source receives the prior state.
- R10: All registers waiting on the same tag capture one broadcast together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue transaction present |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| iss_dst_en | input | 1 | Instruction writes a destination register |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Reservation-station tag of the issuing instruction (0 reserved) |
| src_a_ready | output | 1 | First source value is available |
| src_a_value | output | 32 | First source value, 0 when not ready |
| src_a_tag | output | 4 | First source producer tag, 0 when ready |
| src_b_ready | output | 1 | Second source value is available |
| src_b_value | output | 32 | Second source value, 0 when not ready |
| src_b_tag | output | 4 | Second source producer tag, 0 when ready |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | 4 | Tag of the producing slot |
| res_value | input | 32 | Result value |

## Verification
A register stuck waiting, or one that captured a stale result, shows up on the lookup outputs the first time the register is named as a source. It appears as a wrong ready flag, tag or value in that same cycle. The bench runs a behavioural model of the register values and tags alongside the design and compares both source lookups on every cycle, so a divergence is caught at the first read of the affected register. Directed sequences cover renaming twice before a result arrives, a result colliding with a rename, same-cycle forwarding and a shared tag. A long random stream with few tags then forces frequent tag reuse.

// File: rtl/rnt_pkg.sv
package rnt_pkg;
    localparam int unsigned RNT_NREG   = 16;
    localparam int unsigned RNT_DATA_W = 32;
    localparam int unsigned RNT_TAG_W  = 4;

    typedef enum logic {
        ENT_CURRENT = 1'b0,
        ENT_WAITING = 1'b1
    } ent_state_e;
endpackage

// File: rtl/rnt_entry.sv
module rnt_entry
    import rnt_pkg::*;
#(
    parameter int unsigned DATA_W = RNT_DATA_W,
    parameter int unsigned TAG_W  = RNT_TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ren,
    input  logic [TAG_W-1:0]  new_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    output ent_state_e        state,
    output logic [TAG_W-1:0]  qi,
    output logic [DATA_W-1:0] val
);
    ent_state_e        state_nx;
    logic [TAG_W-1:0]  qi_nx;
    logic [DATA_W-1:0] val_nx;
    logic              capture;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENT_CURRENT;
            qi    <= '0;
            val   <= '0;
        end else begin
            state <= state_nx;
            qi    <= qi_nx;
            val   <= val_nx;
        end
    end

    always_comb begin
        capture  = 1'b0;
        state_nx = state;
        qi_nx    = qi;
        val_nx   = val;
        unique case (state)
            ENT_CURRENT: begin
                if (ren) begin
                    state_nx = ENT_WAITING;
                    qi_nx    = new_tag;
                end
            end
            ENT_WAITING: begin
                capture = res_valid && (res_tag == qi);
                if (capture) begin
                    val_nx = res_value;
                end
                if (ren) begin
                    qi_nx = new_tag;
                end else if (capture) begin
                    state_nx = ENT_CURRENT;
                    qi_nx    = '0;
                end
            end
            default: begin
                state_nx = ENT_CURRENT;
            end
        endcase
    end

    p_rename_r2: assert property (@(posedge clk) disable iff (rst)
        ren |=> (state == ENT_WAITING) && (qi == $past(new_tag)));

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ENT_WAITING && res_valid && res_tag == qi && !ren)
        |=> (state == ENT_CURRENT) && (val == $past(res_value)) && (qi == '0));

    p_stale_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ENT_WAITING && !(res_valid && res_tag == qi) && !ren)
        |=> $stable(val) && $stable(qi) && (state == ENT_WAITING));

    p_current_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ENT_CURRENT && !ren) |=> $stable(val) && (state == ENT_CURRENT));

    p_collide_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ENT_WAITING && res_valid && res_tag == qi && ren)
        |=> (state == ENT_WAITING) && (val == $past(res_value)) && (qi == $past(new_tag)));
endmodule

// File: rtl/rnt_lookup.sv
module rnt_lookup
    import rnt_pkg::*;
#(
    parameter int unsigned NREG   = RNT_NREG,
    parameter int unsigned DATA_W = RNT_DATA_W,
    parameter int unsigned TAG_W  = RNT_TAG_W,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  sel,
    input  logic [NREG-1:0]   waiting,
    input  logic [TAG_W-1:0]  qi_arr  [NREG],
    input  logic [DATA_W-1:0] val_arr [NREG],
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    output logic              ready,
    output logic [DATA_W-1:0] value,
    output logic [TAG_W-1:0]  tag
);
    always_comb begin
        if (!waiting[sel]) begin
            ready = 1'b1;
            value = val_arr[sel];
            tag   = '0;
        end else if (res_valid && (res_tag == qi_arr[sel])) begin
            ready = 1'b1;
            value = res_value;
            tag   = '0;
        end else begin
            ready = 1'b0;
            value = '0;
            tag   = qi_arr[sel];
        end
    end

    p_wait_tag_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (tag != '0));
endmodule

// File: rtl/rnt_table.sv
module rnt_table
    import rnt_pkg::*;
#(
    parameter int unsigned NREG   = RNT_NREG,
    parameter int unsigned DATA_W = RNT_DATA_W,
    parameter int unsigned TAG_W  = RNT_TAG_W,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_src_a,
    input  logic [IDX_W-1:0]  iss_src_b,
    input  logic              iss_dst_en,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    output logic              src_a_ready,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic              src_b_ready,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value
);
    logic              do_rename;
    logic [NREG-1:0]   waiting;
    logic [TAG_W-1:0]  qi_arr  [NREG];
    logic [DATA_W-1:0] val_arr [NREG];

    assign do_rename = iss_valid && iss_dst_en && (iss_tag != '0);

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        ent_state_e st;
        logic       ren;
        assign ren = do_rename && (iss_dst == IDX_W'(g));
        rnt_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_ent (
            .clk       (clk),
            .rst       (rst),
            .ren       (ren),
            .new_tag   (iss_tag),
            .res_valid (res_valid),
            .res_tag   (res_tag),
            .res_value (res_value),
            .state     (st),
            .qi        (qi_arr[g]),
            .val       (val_arr[g])
        );
        assign waiting[g] = (st == ENT_WAITING);
    end

    rnt_lookup #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_look_a (
        .clk (clk), .rst (rst), .sel (iss_src_a), .waiting (waiting),
        .qi_arr (qi_arr), .val_arr (val_arr),
        .res_valid (res_valid), .res_tag (res_tag), .res_value (res_value),
        .ready (src_a_ready), .value (src_a_value), .tag (src_a_tag)
    );

    rnt_lookup #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_look_b (
        .clk (clk), .rst (rst), .sel (iss_src_b), .waiting (waiting),
        .qi_arr (qi_arr), .val_arr (val_arr),
        .res_valid (res_valid), .res_tag (res_tag), .res_value (res_value),
        .ready (src_b_ready), .value (src_b_value), .tag (src_b_tag)
    );

    p_tag_zero_no_rename_r8: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_tag == '0 && !waiting[iss_dst]) |=> !waiting[$past(iss_dst)]);

    p_shared_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !do_rename && $countones(waiting) != 0 &&
         waiting[iss_src_a] && waiting[iss_src_b] &&
         qi_arr[iss_src_a] == res_tag && qi_arr[iss_src_b] == res_tag)
        |=> !waiting[$past(iss_src_a)] && !waiting[$past(iss_src_b)]);
endmodule

// File: tb/test_rnt_table.sv
module test_rnt_table;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int TW   = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          iss_valid, iss_dst_en, res_valid;
    logic [3:0]    iss_src_a, iss_src_b, iss_dst;
    logic [TW-1:0] iss_tag, res_tag;
    logic [DW-1:0] res_value;
    logic          src_a_ready, src_b_ready;
    logic [DW-1:0] src_a_value, src_b_value;
    logic [TW-1:0] src_a_tag, src_b_tag;

    int   vectors = 0;
    int   fails   = 0;
    string cur_req = "R1";

    logic [DW-1:0] m_val [NREG];
    logic [TW-1:0] m_qi  [NREG];

    always #10 clk = ~clk;

    rnt_table i_rnt_table (
        .clk (clk), .rst (rst),
        .iss_valid (iss_valid), .iss_src_a (iss_src_a), .iss_src_b (iss_src_b),
        .iss_dst_en (iss_dst_en), .iss_dst (iss_dst), .iss_tag (iss_tag),
        .src_a_ready (src_a_ready), .src_a_value (src_a_value), .src_a_tag (src_a_tag),
        .src_b_ready (src_b_ready), .src_b_value (src_b_value), .src_b_tag (src_b_tag),
        .res_valid (res_valid), .res_tag (res_tag), .res_value (res_value)
    );

    task automatic idle();
        iss_valid = 0; iss_dst_en = 0; iss_dst = 0; iss_tag = 0;
        iss_src_a = 0; iss_src_b = 0;
        res_valid = 0; res_tag = 0; res_value = 0;
    endtask

    task automatic cmp_src(input string name, input logic [3:0] s,
                           input logic rdy, input logic [DW-1:0] v, input logic [TW-1:0] t);
        logic          e_r;
        logic [DW-1:0] e_v;
        logic [TW-1:0] e_t;
        if (m_qi[s] == 0) begin
            e_r = 1; e_v = m_val[s]; e_t = 0;
        end else if (res_valid && res_tag == m_qi[s]) begin
            e_r = 1; e_v = res_value; e_t = 0;
        end else begin
            e_r = 0; e_v = 0; e_t = m_qi[s];
        end
        vectors++;
        if (rdy !== e_r || v !== e_v || t !== e_t) begin
            fails++;
            $display("FAIL %s src %s reg %0d: got ready=%0b value=%h tag=%0d, expected ready=%0b value=%h tag=%0d",
                     cur_req, name, s, rdy, v, t, e_r, e_v, e_t);
        end
    endtask

    task automatic step();
        #2;
        cmp_src("a", iss_src_a, src_a_ready, src_a_value, src_a_tag);
        cmp_src("b", iss_src_b, src_b_ready, src_b_value, src_b_tag);
        @(posedge clk);
        for (int r = 0; r < NREG; r++) begin
            if (m_qi[r] != 0 && res_valid && res_tag == m_qi[r]) begin
                m_val[r] = res_value;
                m_qi[r]  = 0;
            end
            if (iss_valid && iss_dst_en && iss_tag != 0 && iss_dst == r[3:0])
                m_qi[r] = iss_tag;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic issue(input logic [3:0] d, input logic [TW-1:0] t,
                         input logic [3:0] a, input logic [3:0] b);
        iss_valid = 1; iss_dst_en = 1; iss_dst = d; iss_tag = t;
        iss_src_a = a; iss_src_b = b;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
        res_valid = 1; res_tag = t; res_value = v;
    endtask

    task automatic read(input logic [3:0] a, input logic [3:0] b);
        iss_src_a = a; iss_src_b = b;
        step();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        summary();
    end

    initial begin
        for (int r = 0; r < NREG; r++) begin m_val[r] = 0; m_qi[r] = 0; end
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        cur_req = "R1";
        for (int r = 0; r < NREG; r++) read(r[3:0], 4'(15 - r));

        cur_req = "R2";
        issue(3, 5, 3, 0); step();
        read(3, 3);

        cur_req = "R9";
        issue(4, 6, 4, 3); step();
        issue(4, 12, 4, 4); step();
        read(4, 4);

        cur_req = "R3";
        bcast(5, 32'hAAAA_5555); step();
        read(3, 4);
        bcast(12, 32'h0000_1234); read(4, 4);
        read(4, 3);

        cur_req = "R4";
        issue(7, 2, 7, 7); step();
        issue(7, 9, 7, 7); step();
        bcast(2, 32'hDEAD_BEEF); read(7, 3);
        read(7, 3);
        bcast(6, 32'h1111_2222); read(3, 0);
        read(7, 3);
        bcast(9, 32'h9999_0009); step();
        read(7, 7);

        cur_req = "R6";
        issue(8, 3, 0, 0); step();
        bcast(3, 32'hCAFE_F00D); read(8, 0);
        read(8, 8);

        cur_req = "R7";
        issue(10, 4, 0, 0); step();
        issue(10, 11, 10, 10); bcast(4, 32'h4444_0004); step();
        read(10, 10);
        bcast(11, 32'h0B0B_0B0B); read(10, 0);
        read(10, 10);

        cur_req = "R8";
        issue(12, 0, 12, 12); step();
        read(12, 12);
        issue(12, 7, 12, 12); iss_dst_en = 0; step();
        read(12, 12);
        issue(12, 7, 0, 0); iss_valid = 0; step();
        read(12, 12);

        cur_req = "R10";
        issue(1, 13, 0, 0); step();
        issue(2, 13, 1, 0); step();
        read(1, 2);
        bcast(13, 32'h1313_1313); read(1, 2);
        read(1, 2);

        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            iss_valid  = $urandom_range(0, 3) != 0;
            iss_dst_en = $urandom_range(0, 7) != 0;
            iss_dst    = 4'($urandom_range(0, 15));
            iss_tag    = 4'($urandom_range(0, 7));
            iss_src_a  = 4'($urandom_range(0, 15));
            iss_src_b  = 4'($urandom_range(0, 15));
            res_valid  = $urandom_range(0, 1) != 0;
            res_tag    = 4'($urandom_range(1, 7));
            res_value  = $urandom;
            step();
        end

        summary();
    end
endmodule